// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the register file behind a four-channel DMA controller, reached over an 8-bit port bus. Each channel has a 16-bit address and a 16-bit count, both held as a base copy and a working copy, plus a page byte for address bits 23:16 and a six-bit mode. Software reaches every 16-bit register through a single byte port. A shared byte pointer decides whether an access hits the low byte or the high byte. A dedicated port resets that pointer so that software can start from a known state.

Shared ports mask, unmask, request and withdraw individual channels. A channel number sits in the low two bits of the byte written to these ports. The block does not arbitrate and issues no bus cycles. A transfer-advance strobe tells it that the chosen channel has moved one unit, and the block then updates the working address and count. At terminal count it either reloads the working registers from the base registers or masks the channel. The readback path returns the working values, so software can see how far a transfer has progressed.

Port map (`port_i`): 2n is the address of channel n, 2n+1 is the count of channel n, 8 is the single-channel mask, 9 is the mode, 10 is the request, 11 clears the byte pointer, and 12+n is the page of channel n.

Top module: `dma_port_regs`

## Requirements
- R1: After reset every channel is masked (`mask_o` = 4'hF), no request is pending, `tc_o` is zero, the byte pointer selects the low byte, and the address and count registers read zero.
- R2: Each read or write of an address or count port (ports 0 to 7) hits the low byte and then the high byte on the next access. Any write to port 11 makes the next such access hit the low byte.
- R3: The page port of channel n (port 12+n) writes and reads bits 23:16 of that channel's address. Accessing it leaves the byte pointer unchanged.
- R4: A write to an address or count port loads the selected byte into both the base copy and the working copy. Reads of ports 0 to 7 return the working copy. The count holds the transfer length minus one.
- R5: A write to port 8 with bit 2 set masks the channel given by bits 1:0. The same write with bit 2 clear unmasks that channel. A read of port 8 returns the mask bits in bits 3:0.
- R6: A write to port 10 with bit 2 set raises a request for channel bits 1:0, but only if that channel's service mode is block (10). With bit 2 clear the write withdraws the request.
- R7: A write to port 9 programs the channel given by bits 1:0. Bits 3:2 give the transfer kind, shown on `xfer_kind_o[2n+1:2n]`. Bit 4 selects auto-initialise, bit 5 selects decrement, and bits 7:6 select the service (00 demand, 01 single, 10 block, 11 cascade).
- R8: An advance pulse on a channel that is unmasked and has a request pending moves the working address by +1, or by -1 in decrement mode, and lowers the working count by one. On any other channel the pulse has no effect.
- R9: An advance that finds the count at zero is terminal. The count wraps to 16'hFFFF, `tc_o[n]` is high for the next cycle, the request is cleared, and a channel without auto-initialise becomes masked.
- R10: At terminal count on an auto-initialise channel, the working address and count are reloaded from the base copies and the channel stays unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Port write strobe |
| rd_i | input | 1 | Port read strobe |
| port_i | input | 4 | Port number |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational while rd_i is high |
| adv_i | input | 1 | Transfer-advance strobe |
| adv_ch_i | input | 2 | Channel that advances |
| mask_o | output | 4 | Per-channel mask |
| req_o | output | 4 | Per-channel software request |
| tc_o | output | 4 | Terminal count pulse per channel |
| xfer_kind_o | output | 8 | Transfer kind, two bits per channel |

## Verification
The bench builds the block with its defaults: four channels and an 8-bit page. With these values every port in the map can be decoded, so each channel-select field has a real target. The counts are loaded with small values, so a few advance pulses reach terminal count. Those pulses exercise the wrap to all ones, the reload of an auto-initialise channel counting downward, and the self-mask of a plain channel. The read checks keep the byte pointer in step across clear-port writes and page accesses.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int PORT_W = 4;
  localparam int DATA_W = 8;
  localparam int WORD_W = 16;

  localparam logic [PORT_W-1:0] P_MASK  = 4'd8;
  localparam logic [PORT_W-1:0] P_MODE  = 4'd9;
  localparam logic [PORT_W-1:0] P_REQ   = 4'd10;
  localparam logic [PORT_W-1:0] P_FFCLR = 4'd11;
  localparam logic [PORT_W-1:0] P_PAGE0 = 4'd12;

  typedef enum logic [1:0] {
    SVC_DEMAND  = 2'b00,
    SVC_SINGLE  = 2'b01,
    SVC_BLOCK   = 2'b10,
    SVC_CASCADE = 2'b11
  } svc_e;

  // mode byte bits 7:2
  typedef struct packed {
    svc_e       svc;
    logic       dec;
    logic       auto_init;
    logic [1:0] kind;
  } mode_t;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic hi_o
);
  logic hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= 1'b0;
    else if (clear_i) hi_q <= 1'b0;
    else if (step_i)  hi_q <= ~hi_q;
  end

  assign hi_o = hi_q;

  p_clear_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !hi_o);
  p_step_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i) |=> (hi_o != $past(hi_o)));
  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> $stable(hi_o));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_regs_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_addr_i,
  input  logic              wr_cnt_i,
  input  logic              wr_page_i,
  input  logic              wr_mode_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  input  logic              req_set_i,
  input  logic              req_clr_i,
  input  logic              adv_i,
  output logic [WORD_W-1:0] cur_addr_o,
  output logic [WORD_W-1:0] cur_cnt_o,
  output logic [PAGE_W-1:0] page_o,
  output mode_t             mode_o,
  output logic              mask_o,
  output logic              req_o,
  output logic              tc_o
);
  logic [WORD_W-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
  logic [PAGE_W-1:0] page_q;
  mode_t             mode_q;
  logic              mask_q, req_q, tc_q;
  logic              go, term;

  assign term = (cur_cnt_q == '0);
  assign go   = adv_i && !mask_q && req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      page_q      <= '0;
      mode_q      <= '0;
      mask_q      <= 1'b1;
      req_q       <= 1'b0;
      tc_q        <= 1'b0;
    end else begin
      tc_q <= go && term;
      if (go) begin
        if (term && mode_q.auto_init) begin
          cur_addr_q <= base_addr_q;
          cur_cnt_q  <= base_cnt_q;
        end else begin
          cur_addr_q <= mode_q.dec ? cur_addr_q - 1'b1 : cur_addr_q + 1'b1;
          cur_cnt_q  <= cur_cnt_q - 1'b1;
        end
        if (term) begin
          req_q <= 1'b0;
          if (!mode_q.auto_init) mask_q <= 1'b1;
        end
      end
      // port writes take precedence over a same-cycle advance
      if (wr_addr_i) begin
        if (hi_i) begin
          base_addr_q[WORD_W-1:8] <= wdata_i;
          cur_addr_q[WORD_W-1:8]  <= wdata_i;
        end else begin
          base_addr_q[7:0] <= wdata_i;
          cur_addr_q[7:0]  <= wdata_i;
        end
      end
      if (wr_cnt_i) begin
        if (hi_i) begin
          base_cnt_q[WORD_W-1:8] <= wdata_i;
          cur_cnt_q[WORD_W-1:8]  <= wdata_i;
        end else begin
          base_cnt_q[7:0] <= wdata_i;
          cur_cnt_q[7:0]  <= wdata_i;
        end
      end
      if (wr_page_i) page_q <= wdata_i[PAGE_W-1:0];
      if (wr_mode_i) mode_q <= mode_t'(wdata_i[7:2]);
      if (mask_set_i) mask_q <= 1'b1;
      if (mask_clr_i) mask_q <= 1'b0;
      if (req_set_i && mode_q.svc == SVC_BLOCK) req_q <= 1'b1;
      if (req_clr_i) req_q <= 1'b0;
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;
  assign page_o     = page_q;
  assign mode_o     = mode_q;
  assign mask_o     = mask_q;
  assign req_o      = req_q;
  assign tc_o       = tc_q;

  p_req_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> (mode_q.svc == SVC_BLOCK));
  p_idle_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !wr_addr_i) |=> $stable(cur_addr_q));
  p_tc_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && term && !mode_q.auto_init && !wr_cnt_i) |=> (cur_cnt_q == '1));
  p_tc_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && term && !mode_q.auto_init && !mask_clr_i) |=> (mask_q && !req_q));
  p_reload_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && term && mode_q.auto_init && !wr_cnt_i) |=> (cur_cnt_q == base_cnt_q && !mask_q));
endmodule

// File: rtl/dma_port_regs.sv
module dma_port_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PAGE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [PORT_W-1:0]   port_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                adv_i,
  input  logic [1:0]          adv_ch_i,
  output logic [NUM_CH-1:0]   mask_o,
  output logic [NUM_CH-1:0]   req_o,
  output logic [NUM_CH-1:0]   tc_o,
  output logic [2*NUM_CH-1:0] xfer_kind_o
);
  localparam int NUM_WORD_PORTS = 2 * NUM_CH;

  logic              hi;
  logic              is_word, is_cnt, acc_word, ff_clear;
  logic [1:0]        word_ch, sel_ch;
  logic [WORD_W-1:0] cur_addr [NUM_CH];
  logic [WORD_W-1:0] cur_cnt  [NUM_CH];
  logic [PAGE_W-1:0] page     [NUM_CH];
  mode_t             mode     [NUM_CH];

  assign is_word  = (int'(port_i) < NUM_WORD_PORTS);
  assign is_cnt   = port_i[0];
  assign word_ch  = port_i[2:1];
  assign sel_ch   = wdata_i[1:0];
  assign acc_word = (wr_i || rd_i) && is_word;
  assign ff_clear = wr_i && (port_i == P_FFCLR);

  dma_byte_ptr u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(ff_clear),
    .step_i (acc_word),
    .hi_o   (hi)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit_sel;
    assign hit_sel = (sel_ch == 2'(i));

    dma_chan #(.PAGE_W(PAGE_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hi_i      (hi),
      .wdata_i   (wdata_i),
      .wr_addr_i (wr_i && is_word && !is_cnt && word_ch == 2'(i)),
      .wr_cnt_i  (wr_i && is_word && is_cnt && word_ch == 2'(i)),
      .wr_page_i (wr_i && port_i == P_PAGE0 + PORT_W'(i)),
      .wr_mode_i (wr_i && port_i == P_MODE && hit_sel),
      .mask_set_i(wr_i && port_i == P_MASK && hit_sel && wdata_i[2]),
      .mask_clr_i(wr_i && port_i == P_MASK && hit_sel && !wdata_i[2]),
      .req_set_i (wr_i && port_i == P_REQ && hit_sel && wdata_i[2]),
      .req_clr_i (wr_i && port_i == P_REQ && hit_sel && !wdata_i[2]),
      .adv_i     (adv_i && adv_ch_i == 2'(i)),
      .cur_addr_o(cur_addr[i]),
      .cur_cnt_o (cur_cnt[i]),
      .page_o    (page[i]),
      .mode_o    (mode[i]),
      .mask_o    (mask_o[i]),
      .req_o     (req_o[i]),
      .tc_o      (tc_o[i])
    );

    assign xfer_kind_o[2*i +: 2] = mode[i].kind;
  end

  always_comb begin
    logic [WORD_W-1:0] word;
    rdata_o = '0;
    word    = '0;
    if (rd_i) begin
      if (is_word) begin
        word    = is_cnt ? cur_cnt[word_ch] : cur_addr[word_ch];
        rdata_o = hi ? word[WORD_W-1:8] : word[7:0];
      end else if (port_i >= P_PAGE0 && int'(port_i[1:0]) < NUM_CH) begin
        rdata_o[PAGE_W-1:0] = page[port_i[1:0]];
      end else if (port_i == P_MASK) begin
        rdata_o[NUM_CH-1:0] = mask_o;
      end
    end
  end

  p_mask_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && port_i == P_MASK && wdata_i[2] && int'(sel_ch) < NUM_CH)
      |=> mask_o[$past(sel_ch)]);
  p_tc_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tc_o));
endmodule

// File: tb/tb_dma_port_regs.sv
module tb_dma_port_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, adv_i = 1'b0;
  logic [3:0] port_i = '0;
  logic [7:0] wdata_i = '0;
  logic [1:0] adv_ch_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] mask_o, req_o, tc_o;
  logic [7:0] xfer_kind_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_port_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .port_i(port_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .adv_i(adv_i), .adv_ch_i(adv_ch_i),
    .mask_o(mask_o), .req_o(req_o), .tc_o(tc_o), .xfer_kind_o(xfer_kind_o)
  );

  // monitor: compare read data against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rd_i) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL read with empty scoreboard: actual %02h expected none", rdata_o);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rdata_o !== e) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", t, rdata_o, e);
          end
        end
      end
    end
  end

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] p, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; port_i = p; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] p, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_i = 1'b1; port_i = p;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic adv(input logic [1:0] ch);
    @(negedge clk);
    adv_i = 1'b1; adv_ch_i = ch;
    @(negedge clk);
    adv_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(16'(mask_o), 16'hF, "R1 mask after reset");
    chk(16'(req_o), 16'h0, "R1 req after reset");
    chk(16'(tc_o), 16'h0, "R1 tc after reset");
    rd(4'd0, 8'h00, "R1 addr lo after reset");
    rd(4'd0, 8'h00, "R1 addr hi after reset");
    rd(4'd8, 8'h0F, "R5 mask readback after reset");

    // R2/R4 byte sequencing and base+current load
    wr(4'd11, 8'h00);
    wr(4'd0, 8'h34);
    wr(4'd0, 8'h12);
    wr(4'd1, 8'h02);
    wr(4'd1, 8'h00);
    rd(4'd0, 8'h34, "R2 addr lo");
    rd(4'd0, 8'h12, "R2 addr hi");
    rd(4'd1, 8'h02, "R4 count lo");
    rd(4'd1, 8'h00, "R4 count hi");
    wr(4'd2, 8'hAA);          // pointer now on high byte
    wr(4'd11, 8'h00);         // clear back to low
    rd(4'd2, 8'hAA, "R2 clear forces low byte");
    rd(4'd2, 8'h00, "R2 high byte after clear");

    // R3 page port leaves pointer alone
    wr(4'd12, 8'h5A);
    rd(4'd0, 8'h34, "R3 pointer untouched by page write");
    rd(4'd12, 8'h5A, "R3 page readback");
    rd(4'd0, 8'h12, "R3 pointer untouched by page read");

    // R7 mode: ch0 block, kind 01; ch1 single, kind 00
    wr(4'd9, 8'h84);
    wr(4'd9, 8'h41);
    @(negedge clk);
    chk(16'(xfer_kind_o[1:0]), 16'h1, "R7 ch0 kind");
    chk(16'(xfer_kind_o[3:2]), 16'h0, "R7 ch1 kind");

    // R6 request only for block mode
    wr(4'd10, 8'h05);
    @(negedge clk);
    chk(16'(req_o[1]), 16'h0, "R6 non-block request ignored");
    wr(4'd10, 8'h04);
    @(negedge clk);
    chk(16'(req_o[0]), 16'h1, "R6 block request raised");

    // R8 masked channel does not advance
    adv(2'd0);
    rd(4'd0, 8'h34, "R8 masked addr lo unchanged");
    rd(4'd0, 8'h12, "R8 masked addr hi unchanged");

    // R5 single mask port
    wr(4'd8, 8'h00);
    @(negedge clk);
    chk(16'(mask_o), 16'hE, "R5 unmask ch0");
    wr(4'd8, 8'h03);
    @(negedge clk);
    chk(16'(mask_o), 16'h6, "R5 unmask ch3");
    wr(4'd8, 8'h07);
    @(negedge clk);
    chk(16'(mask_o), 16'hE, "R5 mask ch3");

    // R8 advance incrementing, R9 terminal count
    adv(2'd0);
    rd(4'd0, 8'h35, "R8 addr step lo");
    rd(4'd0, 8'h12, "R8 addr step hi");
    rd(4'd1, 8'h01, "R8 count step lo");
    rd(4'd1, 8'h00, "R8 count step hi");
    adv(2'd0);
    chk(16'(tc_o), 16'h0, "R9 no tc before terminal");
    adv(2'd0);
    chk(16'(tc_o), 16'h1, "R9 tc pulse ch0");
    @(negedge clk);
    chk(16'(tc_o), 16'h0, "R9 tc single cycle");
    chk(16'(mask_o[0]), 16'h1, "R9 self-mask ch0");
    chk(16'(req_o[0]), 16'h0, "R9 request cleared ch0");
    rd(4'd1, 8'hFF, "R9 count wraps lo");
    rd(4'd1, 8'hFF, "R9 count wraps hi");
    rd(4'd0, 8'h37, "R9 addr lo at tc");
    rd(4'd0, 8'h12, "R9 addr hi at tc");

    // R10 auto-initialise with decrement on ch2
    wr(4'd9, 8'hBA);
    wr(4'd4, 8'h00);
    wr(4'd4, 8'h01);
    wr(4'd5, 8'h01);
    wr(4'd5, 8'h00);
    wr(4'd8, 8'h02);
    wr(4'd10, 8'h06);
    @(negedge clk);
    chk(16'(xfer_kind_o[5:4]), 16'h2, "R7 ch2 kind");
    adv(2'd2);
    rd(4'd4, 8'hFF, "R8 decrement lo");
    rd(4'd4, 8'h00, "R8 decrement hi");
    adv(2'd2);
    chk(16'(tc_o), 16'h4, "R10 tc pulse ch2");
    chk(16'(mask_o[2]), 16'h0, "R10 stays unmasked");
    chk(16'(req_o[2]), 16'h0, "R10 request cleared");
    rd(4'd4, 8'h00, "R10 addr reload lo");
    rd(4'd4, 8'h01, "R10 addr reload hi");
    rd(4'd5, 8'h01, "R10 count reload lo");
    rd(4'd5, 8'h00, "R10 count reload hi");

    // R8 no request: no step
    adv(2'd2);
    rd(4'd4, 8'h00, "R8 unrequested addr lo unchanged");
    rd(4'd4, 8'h01, "R8 unrequested addr hi unchanged");

    // R6 withdraw
    wr(4'd10, 8'h06);
    @(negedge clk);
    chk(16'(req_o[2]), 16'h1, "R6 request ch2 again");
    wr(4'd10, 8'h02);
    @(negedge clk);
    chk(16'(req_o[2]), 16'h0, "R6 request withdrawn");

    repeat (2) @(negedge clk);
    chk(16'(exp_q.size()), 16'h0, "scoreboard drained");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule